// File: doc/BRIEF.md
# Data communication channel byte extractor

This block watches the received transport overhead as it arrives one byte at a time. Each byte comes with its row and column position, and a frame start pulse marks the first overhead byte of every frame. From this stream the block picks out the data communication channel bytes and passes them to a byte-wide output with a one-cycle valid strobe. A frame marker flags the first channel byte of each frame.

Two configuration bits control the block. The port enable bit gates all output. The set select bit chooses between two byte sets. With the select bit at 1, the block emits the three regenerator-section bytes D1 to D3. With the select bit at 0, it emits the nine multiplex-section bytes D4 to D12.

Both bits are captured only at a frame start. Each frame is therefore emitted whole with one setting, or not emitted at all. The overhead may be byte-interleaved from several lower-rate signals. Only the first interleaved signal is used.

Top module: `dcc_extract_top`

## Requirements
- R1: After reset, `dcc_vld`, `dcc_sof` and `dcc_data` are 0. The enable and select bits reset to 0, and no byte is emitted until a frame start has sampled `port_en` = 1.
- R2: With a select value of 1 captured at frame start, the block emits exactly the bytes at row 3, columns 1, 3*LANES+1 and 6*LANES+1. These are D1, D2 and D3.
- R3: With a select value of 0 captured at frame start, the block emits exactly the bytes at rows 6, 7 and 8, each at columns 1, 3*LANES+1 and 6*LANES+1. These are D4 to D12.
- R4: An emitted byte appears on `dcc_data` with `dcc_vld` high for one cycle, one clock after its input cycle. Bytes come out in ascending D-number order.
- R5: `dcc_sof` is high together with the first emitted byte of each frame and with no other byte.
- R6: When the enable value captured at frame start is 0, no byte is emitted for that whole frame, whatever the select value is.
- R7: `port_en` and `rs_sel` are sampled only in the cycle where `frm_start` = 1. A change in the middle of a frame has no effect until the next frame start.
- R8: A cycle with `ovh_vld` = 0 is ignored even when its row and column name a channel position. Bytes of other interleaved signals (column-1 not a multiple of LANES) are never emitted.
- R9: Each enabled frame yields exactly 3 bytes (select 1) or 9 bytes (select 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovh_vld | input | 1 | Current cycle carries an overhead byte |
| ovh_byte | input | 8 | Overhead byte value |
| ovh_row | input | 4 | Overhead row, 1 to 9 |
| ovh_col | input | COL_W (6) | Interleaved overhead column, 1 to 9*LANES |
| frm_start | input | 1 | Marks the first overhead byte of a frame |
| port_en | input | 1 | Port enable, captured at frame start |
| rs_sel | input | 1 | 1 selects D1 to D3, 0 selects D4 to D12; captured at frame start |
| dcc_data | output | 8 | Extracted channel byte |
| dcc_vld | output | 1 | `dcc_data` holds a new byte |
| dcc_sof | output | 1 | First extracted byte of the frame |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a frame. The stimulus flips the select bit or the enable bit at row 5 of a frame. The expected bytes are still built from the values held at that frame's start. The stream also contains idle cycles that carry a channel position and a marker value with the byte valid low. Every column of every interleaved signal is sent, so that a wrong lane or position decode shows up as an extra byte or a missing one.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  // interleaved column (1-based) -> index of the lower-rate signal it belongs to
  function automatic int lane_of(input int col, input int lanes);
    return (col - 1) % lanes;
  endfunction

  // interleaved column (1-based) -> column inside its lower-rate signal (1-based)
  function automatic int stm1_col_of(input int col, input int lanes);
    return (col - 1) / lanes + 1;
  endfunction

  // row and lower-rate column -> channel byte number 1..12, or 0 if none
  function automatic int d_number(input int row, input int scol);
    int k;
    if (scol != 1 && scol != 4 && scol != 7) return 0;
    k = (scol - 1) / 3;
    if (row == 3) return 1 + k;
    if (row >= 6 && row <= 8) return 4 + (row - 6) * 3 + k;
    return 0;
  endfunction

endpackage

// File: rtl/dcc_pos_decode.sv
module dcc_pos_decode
  import dcc_pkg::*;
#(
  parameter int LANES = 4,
  parameter int COL_W = 6
) (
  input  logic             ovh_vld,
  input  logic [3:0]       ovh_row,
  input  logic [COL_W-1:0] ovh_col,
  output logic [3:0]       d_num
);

  always_comb begin
    d_num = '0;
    if (ovh_vld && lane_of(int'(ovh_col), LANES) == 0)
      d_num = 4'(d_number(int'(ovh_row), stm1_col_of(int'(ovh_col), LANES)));
  end

endmodule

// File: rtl/dcc_frame_cfg.sv
module dcc_frame_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic port_en,
  input  logic rs_sel,
  output logic act_en,
  output logic act_rs
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en <= 1'b0;
      act_rs <= 1'b0;
    end else if (frm_start) begin
      act_en <= port_en;
      act_rs <= rs_sel;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> ($stable(act_en) && $stable(act_rs))); // R7

endmodule

// File: rtl/dcc_byte_gate.sv
module dcc_byte_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic [3:0] d_num,
  input  logic [7:0] ovh_byte,
  input  logic       act_en,
  input  logic       act_rs,
  output logic [7:0] dcc_data,
  output logic       dcc_vld,
  output logic       dcc_sof
);

  logic       sel_ok;
  logic       pass;
  logic       first_pend;
  logic [3:0] out_num;
  logic [3:0] prev_num;
  logic [3:0] frm_cnt;

  always_comb begin
    if (act_rs) sel_ok = (d_num >= 4'd1) && (d_num <= 4'd3);
    else        sel_ok = (d_num >= 4'd4);
  end

  assign pass = act_en && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcc_data   <= '0;
      dcc_vld    <= 1'b0;
      dcc_sof    <= 1'b0;
      first_pend <= 1'b0;
      out_num    <= '0;
      prev_num   <= '0;
      frm_cnt    <= '0;
    end else begin
      dcc_vld <= pass;
      dcc_sof <= pass && first_pend;
      if (pass) begin
        dcc_data <= ovh_byte;
        out_num  <= d_num;
      end
      if (frm_start) first_pend <= 1'b1;
      else if (pass) first_pend <= 1'b0;
      if (dcc_vld) prev_num <= out_num;
      if (frm_start) frm_cnt <= '0;
      else if (dcc_vld) frm_cnt <= frm_cnt + 4'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dcc_vld && !dcc_sof)); // R1
  AST_RS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dcc_vld && act_rs) |-> (out_num >= 4'd1 && out_num <= 4'd3)); // R2
  AST_MS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dcc_vld && !act_rs) |-> (out_num >= 4'd4 && out_num <= 4'd12)); // R3
  AST_D_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (dcc_vld && !dcc_sof) |-> (out_num == prev_num + 4'd1)); // R4
  AST_SOF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dcc_sof |-> (dcc_vld && frm_cnt == 4'd0)); // R5
  AST_NO_OUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !dcc_vld); // R6
  AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> (frm_cnt == 4'd0 || frm_cnt == 4'd3 || frm_cnt == 4'd9)); // R9

endmodule

// File: rtl/dcc_extract_top.sv
module dcc_extract_top #(
  parameter int LANES = 4,
  parameter int COL_W = $clog2(9 * LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovh_vld,
  input  logic [7:0]       ovh_byte,
  input  logic [3:0]       ovh_row,
  input  logic [COL_W-1:0] ovh_col,
  input  logic             frm_start,
  input  logic             port_en,
  input  logic             rs_sel,
  output logic [7:0]       dcc_data,
  output logic             dcc_vld,
  output logic             dcc_sof
);

  logic [3:0] d_num;
  logic       act_en;
  logic       act_rs;

  dcc_pos_decode #(.LANES(LANES), .COL_W(COL_W)) u_dec (
    .ovh_vld (ovh_vld),
    .ovh_row (ovh_row),
    .ovh_col (ovh_col),
    .d_num   (d_num)
  );

  dcc_frame_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .port_en   (port_en),
    .rs_sel    (rs_sel),
    .act_en    (act_en),
    .act_rs    (act_rs)
  );

  dcc_byte_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .d_num     (d_num),
    .ovh_byte  (ovh_byte),
    .act_en    (act_en),
    .act_rs    (act_rs),
    .dcc_data  (dcc_data),
    .dcc_vld   (dcc_vld),
    .dcc_sof   (dcc_sof)
  );

  AST_PASS_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovh_vld || d_num == 4'd0) |=> !dcc_vld); // R8

endmodule

// File: tb/sim_dcc_extract_top.sv
module sim_dcc_extract_top;
  localparam int N  = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ovh_vld = 1'b0;
  logic [7:0]    ovh_byte = '0;
  logic [3:0]    ovh_row = '0;
  logic [CW-1:0] ovh_col = '0;
  logic          frm_start = 1'b0;
  logic          port_en = 1'b0;
  logic          rs_sel = 1'b0;
  logic [7:0]    dcc_data;
  logic          dcc_vld;
  logic          dcc_sof;

  always #4 clk = ~clk;

  dcc_extract_top #(.LANES(N), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ovh_vld(ovh_vld), .ovh_byte(ovh_byte),
    .ovh_row(ovh_row), .ovh_col(ovh_col), .frm_start(frm_start),
    .port_en(port_en), .rs_sel(rs_sel),
    .dcc_data(dcc_data), .dcc_vld(dcc_vld), .dcc_sof(dcc_sof)
  );

  typedef struct packed { logic [7:0] d; logic s; } exp_t;
  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int got = 0;
  int want = 0;
  string frm_tag = "R6";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // channel position: first lane only, lower-rate column 1/4/7 -> every 3*N interleaved columns
  function automatic bit is_d(input int row, input int col, input bit rs);
    if ((col - 1) % (3 * N) != 0) return 1'b0;
    if (rs) return row == 3;
    return row >= 6 && row <= 8;
  endfunction

  // monitor / scoreboard
  exp_t e;
  always @(posedge clk) begin
    #2;
    if (rst_n && dcc_vld) begin
      got++;
      if (q.size() == 0) chk(1'b0, "R6", "unexpected byte", int'(dcc_data), -1);
      else begin
        e = q.pop_front();
        chk(dcc_data == e.d, "R4", "data", int'(dcc_data), int'(e.d));
        chk(dcc_sof == e.s, "R5", "frame marker", int'(dcc_sof), int'(e.s));
      end
    end
  end

  task automatic check_count();
    chk(got == want, frm_tag, "bytes per frame (R9)", got, want);
    got = 0;
    want = 0;
  endtask

  // mid: 0 none, 1 flip select, 2 enable off, 3 enable on (applied at row 5)
  task automatic send_frame(input int fr, input bit en, input bit rs,
                            input int mid, input string tag);
    bit fen = en;
    bit frs = rs;
    bit first = 1'b1;
    logic [7:0] b;
    check_count();
    frm_tag = tag;
    for (int row = 1; row <= 9; row++) begin
      for (int col = 1; col <= 9 * N; col++) begin
        @(negedge clk);
        if (row == 1 && col == 1) begin port_en = en; rs_sel = rs; end
        if (row == 5 && col == 1) begin
          if (mid == 1) rs_sel = ~rs_sel;
          if (mid == 2) port_en = 1'b0;
          if (mid == 3) port_en = 1'b1;
        end
        b = 8'((fr * 29 + row * 7 + col * 13) & 255);
        ovh_vld = 1'b1; ovh_byte = b; ovh_row = 4'(row); ovh_col = CW'(col);
        frm_start = (row == 1 && col == 1);
        if (fen && is_d(row, col, frs)) begin
          q.push_back({b, first});
          first = 1'b0;
          want++;
        end
        if (col == 12) begin
          @(negedge clk);
          ovh_vld = 1'b0; ovh_byte = 8'hEE; ovh_row = 4'd3; ovh_col = CW'(1);
          frm_start = 1'b0;
        end
      end
    end
    @(negedge clk);
    ovh_vld = 1'b0; frm_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dcc_vld == 1'b0, "R1", "valid after reset", int'(dcc_vld), 0);
    chk(dcc_sof == 1'b0, "R1", "marker after reset", int'(dcc_sof), 0);
    chk(dcc_data == 8'h00, "R1", "data after reset", int'(dcc_data), 0);
    // idle traffic before any frame start: reset enable is 0
    ovh_vld = 1'b1; ovh_row = 4'd3; ovh_col = CW'(1); ovh_byte = 8'h5A;
    port_en = 1'b1; rs_sel = 1'b1;
    repeat (3) @(negedge clk);
    ovh_vld = 1'b0;
    port_en = 1'b0; rs_sel = 1'b0;
    frm_tag = "R1";
    send_frame(0, 1'b0, 1'b0, 0, "R6");
    send_frame(1, 1'b1, 1'b1, 0, "R2");
    send_frame(2, 1'b1, 1'b0, 0, "R3");
    send_frame(3, 1'b1, 1'b1, 1, "R7");
    send_frame(4, 1'b1, 1'b0, 2, "R7");
    send_frame(5, 1'b0, 1'b1, 3, "R6");
    send_frame(6, 1'b0, 1'b0, 1, "R6");
    send_frame(7, 1'b1, 1'b0, 0, "R8");
    send_frame(8, 1'b1, 1'b1, 0, "R9");
    repeat (4) @(negedge clk);
    check_count();
    chk(q.size() == 0, "R9", "leftover expected bytes", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule